// File: doc/BRIEF.md
# Serial Transmitter with Hard Clear-to-Send Abort

This block is the transmit half of an asynchronous serial port that has a single byte of buffering. The CPU writes a byte into a holding register. When the shifter is idle, the byte moves into a shift register. The shifter sends it on the line as an NRZ frame, timed by a 16x bit-rate enable pulse. The frame format is sampled when each byte is loaded and is set by three fields:

- the character length, from 5 to 8 bits;
- one of five parity modes;
- a request for one or two stop bits. The block shortens this request automatically for the shortest and the longest framed characters.

The low-active clear-to-send input is a hard override, not a polite pause. While it is high, the line is forced to the idle level within the same cycle, and every bit of the shift register is overwritten with ones. The frame in flight is therefore lost, and nothing records the loss. A break request drives the line low once the current frame has finished. The low-active request-to-send output is released high only when its control field is zero and the transmitter is truly quiet.

Top module: `serial_tx_hard_cts`

## Requirements
- R1: After synchronous reset, `txd` is 1, `hold_empty` is 1 and, with `rts_ctl` = 0 and `brk_req` = 0, `rts_n` is 1.
- R2: A frame starts with a 0 start bit, followed by the data bits least significant bit first. Every bit lasts 16 pulses of `tick16`.
- R3: `char_len` selects the number of data bits as 5 + `char_len`: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above that count are not sent.
- R4: `parity_mode` adds one bit after the data:
  - 1: odd parity.
  - 2: even parity.
  - 3: constant 1.
  - 4: constant 0.
  - 0 (or 5 to 7): no parity bit.
- R5: The stop level lasts 16 ticks when `two_stop` = 0. With `two_stop` = 1 it lasts:
  - 24 ticks for 5 data bits without parity;
  - 16 ticks for 8 data bits with parity;
  - 32 ticks in every other case.

  The frame ends when the stop time has elapsed.
- R6: `hold_empty` falls in the cycle after a write. It rises when the byte is moved into the idle shifter. A byte written during a frame is sent directly after that frame.
- R7: While `cts_n` is 1, `txd` is 1 in the same cycle, including in the middle of a frame.
- R8: While `cts_n` is 1, the shift register is filled with ones. The remaining bits of the interrupted frame go out as 1, the frame keeps its length, and no byte is loaded.
- R9: `rts_n` is 1 only when `rts_ctl` is 0, no frame is being shifted and no break is being sent. Otherwise it is 0.
- R10: When `brk_req` is 1, a frame already in progress completes. After that `txd` stays 0 for as long as the request is held. A byte written meanwhile waits in the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| char_len | input | 2 | Data bit count minus 5 |
| parity_mode | input | 3 | Parity selection (see R4) |
| two_stop | input | 1 | Request for two stop bits |
| rts_ctl | input | 3 | Request-to-send control field; zero allows release |
| brk_req | input | 1 | Break request |
| cts_n | input | 1 | Clear to send, low active |
| txd | output | 1 | Serial data line, idle high |
| rts_n | output | 1 | Request to send, low active |
| hold_empty | output | 1 | Holding register can accept a byte |

## Verification
Clear-to-send can be deasserted in the same cycle in which a data bit is being driven, so the override and the normal shifting collide. The bench raises `cts_n` in the middle of a zero-valued data bit of an all-zero byte. It expects the line to read 1 immediately, before any clock edge, and the later bits of that same frame to come out as 1 after `cts_n` returns low. Break and frame completion also meet at the last stop tick. For that case the bench asserts the break mid-frame and expects the remaining data bits intact, then a low line that starts at the end of the frame and holds a queued byte back.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_ODD   = 3'd1,
    PAR_EVEN  = 3'd2,
    PAR_MARK  = 3'd3,
    PAR_SPACE = 3'd4
  } par_mode_e;

  localparam int MIN_BITS = 5;
endpackage

// File: rtl/sertx_holding.sv
module sertx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_full <= 1'b0;
    end else if (wr_en) begin
      hold_data <= wr_data;
      hold_full <= 1'b1;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  // a write always leaves the holding register occupied
  p_write_fills_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> hold_full);
  // a transfer without a competing write frees it
  p_take_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (take && !wr_en) |=> !hold_full);
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TPB    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        char_len,
  input  logic [2:0]        parity_mode,
  input  logic              two_stop,
  input  logic              cts_n,
  output logic              busy,
  output logic              line_bit
);
  localparam int SR_W   = DATA_W + 2;
  localparam int SUB_W  = $clog2(TPB);
  localparam int MAXT   = TPB * (DATA_W + 2) + 2 * TPB;
  localparam int TOT_W  = $clog2(MAXT + 1);
  localparam int STOP1  = TPB;
  localparam int STOP15 = TPB + TPB / 2;
  localparam int STOP2  = 2 * TPB;

  logic [SR_W-1:0]  sr, frame_vec;
  logic [SUB_W-1:0] sub;
  logic [TOT_W-1:0] left, frame_len;
  par_mode_e        pm;
  int               nbits, stop_t;
  logic             pen, pbit, acc;

  always_comb begin
    pm        = par_mode_e'(parity_mode);
    nbits     = MIN_BITS + int'(char_len);
    frame_vec = '1;
    frame_vec[0] = 1'b0;
    acc       = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nbits) begin
        frame_vec[i+1] = data[i];
        acc = acc ^ data[i];
      end
    end
    pen  = 1'b1;
    pbit = 1'b1;
    case (pm)
      PAR_ODD:   pbit = ~acc;
      PAR_EVEN:  pbit = acc;
      PAR_MARK:  pbit = 1'b1;
      PAR_SPACE: pbit = 1'b0;
      default:   pen  = 1'b0;
    endcase
    if (pen) frame_vec[nbits+1] = pbit;
    if (!two_stop)                          stop_t = STOP1;
    else if (nbits == MIN_BITS && !pen)     stop_t = STOP15;
    else if (nbits == DATA_W && pen)        stop_t = STOP1;
    else                                    stop_t = STOP2;
    frame_len = TOT_W'(TPB * (1 + nbits + int'(pen)) + stop_t);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sr   <= '1;
      sub  <= '0;
      left <= '0;
    end else begin
      if (load) begin
        busy <= 1'b1;
        sr   <= frame_vec;
        sub  <= '0;
        left <= frame_len;
      end else if (busy && tick16) begin
        sub  <= (sub == SUB_W'(TPB - 1)) ? '0 : sub + 1'b1;
        left <= left - 1'b1;
        if (sub == SUB_W'(TPB - 1)) sr <= {1'b1, sr[SR_W-1:1]};
        if (left == TOT_W'(1)) busy <= 1'b0;
      end
      if (cts_n) sr <= '1;
    end
  end

  assign line_bit = sr[0];

  // clear-to-send high wipes the whole shift register
  p_cts_fill_r8: assert property (@(posedge clk) disable iff (rst)
    cts_n |=> (sr == '1));
  // a newly started frame presents its start bit
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !sr[0]);
endmodule

// File: rtl/serial_tx_hard_cts.sv
module serial_tx_hard_cts #(
  parameter int DATA_W = 8,
  parameter int TPB    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        char_len,
  input  logic [2:0]        parity_mode,
  input  logic              two_stop,
  input  logic [2:0]        rts_ctl,
  input  logic              brk_req,
  input  logic              cts_n,
  output logic              txd,
  output logic              rts_n,
  output logic              hold_empty
);
  logic [DATA_W-1:0] hold_data;
  logic              hold_full, busy, line_bit, load;

  assign load = hold_full && !busy && !cts_n && !brk_req;

  sertx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(load), .hold_data(hold_data), .hold_full(hold_full)
  );

  sertx_framer #(.DATA_W(DATA_W), .TPB(TPB)) u_frame (
    .clk(clk), .rst(rst), .tick16(tick16), .load(load), .data(hold_data),
    .char_len(char_len), .parity_mode(parity_mode), .two_stop(two_stop),
    .cts_n(cts_n), .busy(busy), .line_bit(line_bit)
  );

  assign hold_empty = !hold_full;
  assign txd   = cts_n | (busy ? line_bit : !brk_req);
  assign rts_n = (rts_ctl == 3'd0) && !busy && !brk_req;

  // a transfer from the holding register always starts the shifter
  p_load_starts_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
  // no transfer may happen while the line is held by a break
  p_break_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (brk_req && !busy && hold_full && !wr_en) |=> hold_full);
endmodule

// File: tb/test_serial_tx_hard_cts.sv
module test_serial_tx_hard_cts;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst = 1'b1, tick16 = 1'b0, wr_en = 1'b0, two_stop = 1'b0;
  logic       brk_req = 1'b0, cts_n = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'd3;
  logic [2:0] parity_mode = 3'd0, rts_ctl = 3'd0;
  logic       txd, rts_n, hold_empty;

  int n_chk = 0, n_bad = 0, tick_cnt = 0;
  logic [1:0] div = '0;

  serial_tx_hard_cts i_serial_tx_hard_cts (
    .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .char_len(char_len), .parity_mode(parity_mode), .two_stop(two_stop),
    .rts_ctl(rts_ctl), .brk_req(brk_req), .cts_n(cts_n),
    .txd(txd), .rts_n(rts_n), .hold_empty(hold_empty)
  );

  always @(posedge clk) begin
    div    <= div + 2'd1;
    tick16 <= (div == 2'd3);
    if (tick16) tick_cnt <= tick_cnt + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_tick(input int target);
    while (tick_cnt < target) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_cfg(input int nb, input int pm, input bit st2);
    @(negedge clk);
    char_len = 2'(nb - 5); parity_mode = 3'(pm); two_stop = st2;
  endtask

  // checks one frame on the line; frame must end with rts_ctl 0 and no break
  task automatic expect_frame(input logic [7:0] d, input int nb, input int pm,
                              input bit st2, input bit started, input string req);
    int t0, pen, pos, stop_t;
    logic p;
    if (!started) while (txd !== 1'b0) @(negedge clk);
    t0 = tick_cnt;
    wait_tick(t0 + 8);
    chk("R2", {req, " start bit"}, txd, 0);
    p = 1'b0;
    for (int k = 0; k < nb; k++) begin
      wait_tick(t0 + 16 * (k + 1) + 8);
      chk(req, $sformatf("data bit %0d", k), txd, d[k]);
      p ^= d[k];
    end
    pen = (pm >= 1 && pm <= 4) ? 1 : 0;
    if (pen == 1) begin
      wait_tick(t0 + 16 * (nb + 1) + 8);
      case (pm)
        1: chk("R4", "odd parity", txd, !p);
        2: chk("R4", "even parity", txd, p);
        3: chk("R4", "mark parity", txd, 1);
        default: chk("R4", "space parity", txd, 0);
      endcase
    end
    pos = 1 + nb + pen;
    wait_tick(t0 + 16 * pos + 8);
    chk("R5", {req, " stop level"}, txd, 1);
    if (!st2) stop_t = 16;
    else if (nb == 5 && pen == 0) stop_t = 24;
    else if (nb == 8 && pen == 1) stop_t = 16;
    else stop_t = 32;
    while (rts_n !== 1'b1) @(negedge clk);
    chk("R5", {req, " frame length in ticks"}, tick_cnt - t0, 16 * pos + stop_t);
  endtask

  task automatic t_reset;
    chk("R1", "txd after reset", txd, 1);
    chk("R1", "rts_n after reset", rts_n, 1);
    chk("R1", "hold_empty after reset", hold_empty, 1);
  endtask

  task automatic t_formats;
    set_cfg(8, 0, 0); write_byte(8'hA5); expect_frame(8'hA5, 8, 0, 0, 0, "R2");
    set_cfg(7, 2, 1); write_byte(8'hB5); expect_frame(8'hB5, 7, 2, 1, 0, "R3");
    set_cfg(5, 0, 1); write_byte(8'hF3); expect_frame(8'hF3, 5, 0, 1, 0, "R3");
    set_cfg(8, 1, 1); write_byte(8'h3D); expect_frame(8'h3D, 8, 1, 1, 0, "R4");
    set_cfg(6, 3, 0); write_byte(8'h2A); expect_frame(8'h2A, 6, 3, 0, 0, "R4");
    set_cfg(6, 4, 1); write_byte(8'h15); expect_frame(8'h15, 6, 4, 1, 0, "R5");
    set_cfg(5, 1, 0); write_byte(8'h0E); expect_frame(8'h0E, 5, 1, 0, 0, "R3");
  endtask

  task automatic t_holding;
    set_cfg(8, 0, 0);
    write_byte(8'h81);
    chk("R6", "hold_empty after write", hold_empty, 0);
    @(negedge clk);
    chk("R6", "hold_empty after transfer", hold_empty, 1);
    write_byte(8'h7E);
    chk("R6", "hold_empty with byte queued", hold_empty, 0);
    expect_frame(8'h81, 8, 0, 0, 1, "R6");
    expect_frame(8'h7E, 8, 0, 0, 0, "R6");
    chk("R6", "hold_empty after both frames", hold_empty, 1);
  endtask

  task automatic t_cts;
    int t0;
    set_cfg(8, 0, 0);
    write_byte(8'h00);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_cnt;
    wait_tick(t0 + 16 * 2 + 8);
    chk("R2", "zero data bit before abort", txd, 0);
    cts_n = 1'b1; #1;
    chk("R7", "txd forced high at once", txd, 1);
    @(negedge clk); @(negedge clk);
    cts_n = 1'b0;
    wait_tick(t0 + 16 * 4 + 8);
    chk("R8", "later zero bit sent as one", txd, 1);
    wait_tick(t0 + 16 * 8 + 8);
    chk("R8", "last zero bit sent as one", txd, 1);
    while (rts_n !== 1'b1) @(negedge clk);
    chk("R8", "interrupted frame length", tick_cnt - t0, 160);
    chk("R8", "no status change after loss", hold_empty, 1);
    @(negedge clk); cts_n = 1'b1;
    write_byte(8'h33);
    repeat (200) @(negedge clk);
    chk("R8", "no load while cts_n high", hold_empty, 0);
    chk("R9", "rts_n high while idle and blocked", rts_n, 1);
    cts_n = 1'b0;
    expect_frame(8'h33, 8, 0, 0, 0, "R8");
  endtask

  task automatic t_rts;
    @(negedge clk); rts_ctl = 3'b010; #1;
    chk("R9", "rts_n low with field nonzero", rts_n, 0);
    @(negedge clk); rts_ctl = 3'b000; #1;
    chk("R9", "rts_n high with field zero and idle", rts_n, 1);
    write_byte(8'h55);
    @(negedge clk);
    chk("R9", "rts_n low while shifting", rts_n, 0);
    expect_frame(8'h55, 8, 0, 0, 1, "R9");
  endtask

  task automatic t_break;
    int t0;
    set_cfg(8, 0, 0);
    write_byte(8'hFF);
    while (txd !== 1'b0) @(negedge clk);
    t0 = tick_cnt;
    wait_tick(t0 + 16 * 2 + 8);
    brk_req = 1'b1;
    wait_tick(t0 + 16 * 3 + 8);
    chk("R10", "frame continues under break", txd, 1);
    wait_tick(t0 + 16 * 9 + 8);
    chk("R10", "stop bit kept under break", txd, 1);
    wait_tick(t0 + 160 + 4);
    chk("R10", "line low after frame", txd, 0);
    chk("R9", "rts_n low during break", rts_n, 0);
    write_byte(8'h5A);
    repeat (200) @(negedge clk);
    chk("R10", "byte held during break", hold_empty, 0);
    chk("R10", "line still low", txd, 0);
    brk_req = 1'b0;
    @(negedge clk);
    expect_frame(8'h5A, 8, 0, 0, 1, "R10");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_formats();
    t_holding();
    t_cts();
    t_rts();
    t_break();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule